// File: doc/BRIEF.md
# DMA Global Operation Register with Cycle-Steal Pacer

This block is the global control and status word of a multi-channel DMA controller. It also contains the unit that spaces out cycle-steal transfers. Software reaches the 16-bit word over a single-location register bus.

- **Fields:** the word carries a master enable, a two-bit pacing select, an address-error flag and an NMI flag. Both flags are raised by hardware events. Software can clear a flag only after it has first observed the flag as 1 through a register read.
- **Transfer enable:** the block gates the whole controller through a transfer-enable output.
- **Pacing:** it converts the channels' shared transfer request into a grant.
  - When intermittent pacing is selected and every channel reports cycle-steal bus mode, a grant is followed by a dead window of 16 or 64 bus clocks.
  - In every other case a request is granted in the same cycle, as long as transfers are enabled.

The read data is a combinational view of the register. The read strobe marks the cycle in which software actually samples it, and that marking is what arms the flag-clear mechanism.

Top module: `dma_opreg_pacer`

## Requirements
- R1: After reset every register bit reads 0, and `xfer_en` and `xfer_grant` are 0.
- R2: Bits 15:14 and 11:3 always read as 0, whatever value is written to them.
- R3: Bit 0 (master enable, mirrored on `dma_master_en`) and bits 13:12 (pacing select) take the written value and read it back.
- R4: Writing 1 to bit 2 (address-error flag) or bit 1 (NMI flag) never sets that flag. Only `addr_err_set` or `nmi_set` sets it.
- R5: A cycle with `addr_err_set` high makes bit 2 read 1 from the next cycle on. A cycle with `nmi_set` high does the same for bit 1.
- R6: A write of 0 to a flag bit leaves the flag at 1 unless a read strobe has returned that flag as 1 since the last write of 0 to it.
- R7: After a read strobe that returned a flag as 1, the next write of 0 to that bit clears the flag. That write also disarms the clear, so a later write of 0 without a new read has no effect. Writing 1 to the bit keeps the clear armed.
- R8: If a hardware set and a valid clear of the same flag fall in the same cycle, the flag stays 1.
- R9: `xfer_en` is 1 exactly when bit 0 is 1 and bits 2 and 1 are both 0.
- R10: With pacing select 00 or 01, or with any bit of `chan_cs_mode` low, `xfer_grant` equals `xfer_req & xfer_en` in every cycle.
- R11: With pacing select 10 and all channels in cycle-steal mode, a held request is granted once every 16 clocks. No two grants are closer than 16 clocks.
- R12: With pacing select 11 and all channels in cycle-steal mode, a held request is granted once every 64 clocks.
- R13: `xfer_grant` is never 1 while `xfer_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; marks the cycle software samples `reg_rdata` |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register contents |
| addr_err_set | input | 1 | Hardware event that sets the address-error flag |
| nmi_set | input | 1 | Hardware event that sets the NMI flag |
| chan_cs_mode | input | NUM_CH | Per-channel indication of cycle-steal bus mode |
| xfer_req | input | 1 | Request for a transfer from the channels |
| dma_master_en | output | 1 | Master enable bit |
| xfer_en | output | 1 | Transfers permitted (enable set, no flag pending) |
| xfer_grant | output | 1 | Transfer grant pulse |

## Verification
The hardest condition to reach is a hardware set that lands on the very cycle of a valid clear. A valid clear needs an armed flag: the flag must already be 1, and a read strobe must have returned it as 1. The stimulus therefore raises the flag, performs a strobed read, and only then drives the clearing write together with a new set pulse in one clock. The pacing windows are checked by holding the request high for several hundred clocks and measuring every gap between grants. Before the slower mode is selected, the request is dropped long enough for any leftover dead window to drain.

// File: rtl/dmaop_pkg.sv
package dmaop_pkg;
  localparam int REG_W   = 16;
  localparam int DME_BIT = 0;
  localparam int NMI_BIT = 1;
  localparam int AE_BIT  = 2;
  localparam int SEL_LO  = 12;
  localparam int SEL_HI  = 13;
  localparam int NUM_FLAGS = 2;

  typedef enum logic [1:0] {
    PACE_FREE = 2'b00,
    PACE_BAD  = 2'b01,
    PACE_FAST = 2'b10,
    PACE_SLOW = 2'b11
  } pace_sel_e;
endpackage

// File: rtl/dmaop_flag.sv
module dmaop_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_q
);
  logic flag_d;
  logic armed_q;
  logic armed_d;
  logic upd;

  assign upd = hw_set | rd_stb | wr_stb;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (wr_stb && !wr_bit) begin
      if (armed_q) flag_d = 1'b0;
      armed_d = 1'b0;
    end else if (rd_stb && flag_q) begin
      armed_d = 1'b1;
    end
    if (hw_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (upd) begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dmaop_ctrl.sv
module dmaop_ctrl
  import dmaop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output logic             dme_q,
  output logic [1:0]       sel_q
);
  logic       dme_d;
  logic [1:0] sel_d;

  always_comb begin
    dme_d = wdata[DME_BIT];
    sel_d = wdata[SEL_HI:SEL_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dme_q <= 1'b0;
      sel_q <= PACE_FREE;
    end else if (wr_stb) begin
      dme_q <= dme_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/dmaop_pacer.sv
module dmaop_pacer
  import dmaop_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int FAST_GAP  = 16,
  parameter int SLOW_GAP  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pace_sel,
  input  logic [NUM_CH-1:0] chan_cs,
  input  logic              xfer_en,
  input  logic              xfer_req,
  output logic              xfer_grant
);
  localparam int CNT_W = (SLOW_GAP > FAST_GAP) ? $clog2(SLOW_GAP) : $clog2(FAST_GAP);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_GAP - 1);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_GAP - 1);

  logic             throttle;
  logic             window_open;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign throttle    = (pace_sel == PACE_FAST || pace_sel == PACE_SLOW) && (&chan_cs);
  assign window_open = (cnt_q == '0);
  assign xfer_grant  = xfer_req && xfer_en && (!throttle || window_open);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (xfer_grant && throttle) begin
      cnt_en = 1'b1;
      cnt_d  = (pace_sel == PACE_SLOW) ? SLOW_LD : FAST_LD;
    end else if (!window_open) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_opreg_pacer.sv
module dma_opreg_pacer
  import dmaop_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FAST_GAP = 16,
  parameter int SLOW_GAP = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              addr_err_set,
  input  logic              nmi_set,
  input  logic [NUM_CH-1:0] chan_cs_mode,
  input  logic              xfer_req,
  output logic              dma_master_en,
  output logic              xfer_en,
  output logic              xfer_grant
);
  localparam int FLAG_POS [NUM_FLAGS] = '{NMI_BIT, AE_BIT};

  logic                 dme;
  logic [1:0]           sel;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flag_set;

  assign flag_set = {addr_err_set, nmi_set};

  dmaop_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (reg_wr),
    .wdata  (reg_wdata),
    .dme_q  (dme),
    .sel_q  (sel)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    dmaop_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (flag_set[i]),
      .rd_stb (reg_rd),
      .wr_stb (reg_wr),
      .wr_bit (reg_wdata[FLAG_POS[i]]),
      .flag_q (flags[i])
    );
  end

  always_comb begin
    reg_rdata                = '0;
    reg_rdata[SEL_HI:SEL_LO] = sel;
    reg_rdata[DME_BIT]       = dme;
    for (int i = 0; i < NUM_FLAGS; i++) reg_rdata[FLAG_POS[i]] = flags[i];
  end

  assign dma_master_en = dme;
  assign xfer_en       = dme && (flags == '0);

  dmaop_pacer #(
    .NUM_CH   (NUM_CH),
    .FAST_GAP (FAST_GAP),
    .SLOW_GAP (SLOW_GAP)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pace_sel   (sel),
    .chan_cs    (chan_cs_mode),
    .xfer_en    (xfer_en),
    .xfer_req   (xfer_req),
    .xfer_grant (xfer_grant)
  );
endmodule

// File: rtl/dmaop_chk.sv
module dmaop_chk #(
  parameter int NUM_CH   = 4,
  parameter int FAST_GAP = 16,
  parameter int SLOW_GAP = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              addr_err_set,
  input logic              nmi_set,
  input logic [NUM_CH-1:0] chan_cs_mode,
  input logic              dma_master_en,
  input logic              xfer_en,
  input logic              xfer_grant
);
  localparam int SW = $clog2(SLOW_GAP + FAST_GAP) + 2;
  localparam logic [SW-1:0] SMAX = '1;

  logic          thr_now;
  logic [SW-1:0] since_q;
  logic          hold_q;
  logic          hold_sel_q;

  assign thr_now = reg_rdata[13] && (&chan_cs_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= SMAX;
      hold_q     <= 1'b0;
      hold_sel_q <= 1'b0;
    end else if (xfer_grant) begin
      since_q    <= SW'(1);
      hold_q     <= thr_now;
      hold_sel_q <= reg_rdata[12];
    end else begin
      if (since_q != SMAX) since_q <= since_q + 1'b1;
      hold_q <= hold_q && thr_now && (reg_rdata[12] == hold_sel_q);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:14] == 2'b00) && (reg_rdata[11:3] == '0)) else $error("reserved bits"); // R2
  AST_AE_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[2]) |-> $past(addr_err_set)) else $error("ae self set"); // R4
  AST_NMI_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[1]) |-> $past(nmi_set)) else $error("nmi self set"); // R4
  AST_AE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_set |=> reg_rdata[2]) else $error("ae not set"); // R5
  AST_AE_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[2]) |-> $past(reg_wr && !reg_wdata[2])) else $error("ae fell"); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_set && reg_wr && !reg_wdata[1]) |=> reg_rdata[1]) else $error("set lost"); // R8
  AST_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en == (dma_master_en && !reg_rdata[2] && !reg_rdata[1])) else $error("en"); // R9
  AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_grant |-> xfer_en) else $error("grant w/o en"); // R13
  AST_PACE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_grant && hold_q && thr_now && (reg_rdata[12] == hold_sel_q))
      |-> (int'(since_q) >= (hold_sel_q ? SLOW_GAP : FAST_GAP))) else $error("spacing"); // R11
endmodule

bind dma_opreg_pacer dmaop_chk #(
  .NUM_CH   (NUM_CH),
  .FAST_GAP (FAST_GAP),
  .SLOW_GAP (SLOW_GAP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .addr_err_set  (addr_err_set),
  .nmi_set       (nmi_set),
  .chan_cs_mode  (chan_cs_mode),
  .dma_master_en (dma_master_en),
  .xfer_en       (xfer_en),
  .xfer_grant    (xfer_grant)
);

// File: tb/dma_opreg_pacer_test.sv
module dma_opreg_pacer_test;
  localparam int NUM_CH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              reg_wr, reg_rd;
  logic [15:0]       reg_wdata, reg_rdata;
  logic              addr_err_set, nmi_set;
  logic [NUM_CH-1:0] chan_cs_mode;
  logic              xfer_req;
  logic              dma_master_en, xfer_en, xfer_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dma_opreg_pacer #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_err_set(addr_err_set), .nmi_set(nmi_set),
    .chan_cs_mode(chan_cs_mode), .xfer_req(xfer_req),
    .dma_master_en(dma_master_en), .xfer_en(xfer_en), .xfer_grant(xfer_grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d);
    reg_rd = 1'b1; @(negedge clk); d = reg_rdata; step(); reg_rd = 1'b0;
  endtask

  task automatic pulse_ae();
    addr_err_set = 1'b1; step(); addr_err_set = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi_set = 1'b1; step(); nmi_set = 1'b0;
  endtask

  task automatic t_reset();
    chk(reg_rdata == 16'h0, "R1 rdata", reg_rdata, 0);
    chk(xfer_en == 1'b0 && xfer_grant == 1'b0, "R1 en/grant", {xfer_en, xfer_grant}, 0);
  endtask

  task automatic t_fields();
    wr(16'hFFFF);
    chk(reg_rdata == 16'h3001, "R2 reserved/flags after all-ones", reg_rdata, 16'h3001);
    chk(dma_master_en == 1'b1, "R3 master enable", dma_master_en, 1);
    chk(reg_rdata[2:1] == 2'b00, "R4 write 1 no set", reg_rdata[2:1], 0);
    wr(16'h0000);
    chk(reg_rdata == 16'h0000, "R3 clear fields", reg_rdata, 0);
    wr(16'h2001);
    chk(reg_rdata == 16'h2001, "R3 sel 10", reg_rdata, 16'h2001);
    wr(16'h0001);
  endtask

  task automatic t_ae_flag();
    logic [15:0] v;
    chk(xfer_en == 1'b1, "R9 enabled clean", xfer_en, 1);
    pulse_ae();
    chk(reg_rdata[2] == 1'b1, "R5 ae set", reg_rdata[2], 1);
    chk(xfer_en == 1'b0, "R9 ae blocks", xfer_en, 0);
    wr(16'h0001);
    chk(reg_rdata[2] == 1'b1, "R6 clear w/o read", reg_rdata[2], 1);
    rd(v);
    chk(v == 16'h0005, "R5 read value", v, 16'h0005);
    wr(16'h0001);
    chk(reg_rdata[2] == 1'b0, "R7 clear after read", reg_rdata[2], 0);
    chk(xfer_en == 1'b1, "R9 re-enabled", xfer_en, 1);
    pulse_ae();
    wr(16'h0001);
    chk(reg_rdata[2] == 1'b1, "R7 latch consumed", reg_rdata[2], 1);
    rd(v);
    addr_err_set = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0001;
    step();
    addr_err_set = 1'b0; reg_wr = 1'b0;
    chk(reg_rdata[2] == 1'b1, "R8 set beats clear", reg_rdata[2], 1);
    rd(v);
    wr(16'h0001);
    chk(reg_rdata[2] == 1'b0, "R7 final ae clear", reg_rdata[2], 0);
  endtask

  task automatic t_nmi_flag();
    logic [15:0] v;
    pulse_nmi();
    chk(reg_rdata[1] == 1'b1, "R5 nmi set", reg_rdata[1], 1);
    rd(v);
    wr(16'h0003);
    chk(reg_rdata[1] == 1'b1, "R7 write 1 keeps nmi", reg_rdata[1], 1);
    wr(16'h0001);
    chk(reg_rdata[1] == 1'b0, "R7 nmi cleared", reg_rdata[1], 0);
  endtask

  task automatic t_no_enable();
    wr(16'h0000);
    xfer_req = 1'b1;
    @(negedge clk);
    chk(xfer_grant == 1'b0, "R13 no grant when disabled", xfer_grant, 0);
    step(); xfer_req = 1'b0;
  endtask

  task automatic t_free(input logic [15:0] cfg, input logic [NUM_CH-1:0] cs, input string tag);
    int n = 0;
    wr(cfg); chan_cs_mode = cs; xfer_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (xfer_grant) n++;
    end
    step(); xfer_req = 1'b0;
    chk(n == 20, tag, n, 20);
  endtask

  task automatic t_paced(input logic [15:0] cfg, input int gap, input int cycles, input string tag);
    int last = -1;
    int n = 0;
    xfer_req = 1'b0;
    repeat (80) step();
    chan_cs_mode = '1; wr(cfg); xfer_req = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (xfer_grant) begin
        if (last >= 0) chk(i - last == gap, tag, i - last, gap);
        last = i; n++;
      end
    end
    step(); xfer_req = 1'b0;
    chk(n == (cycles + gap - 1) / gap, tag, n, (cycles + gap - 1) / gap);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    addr_err_set = 1'b0; nmi_set = 1'b0; chan_cs_mode = '0; xfer_req = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fields();
    t_ae_flag();
    t_nmi_flag();
    t_no_enable();
    t_free(16'h0001, '1, "R10 sel 00");
    t_free(16'h1001, '1, "R10 sel 01");
    t_free(16'h2001, 4'b0111, "R10 not all cycle-steal");
    t_paced(16'h2001, 16, 200, "R11 gap 16");
    t_paced(16'h3001, 64, 300, "R12 gap 64");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule